// File: doc/BRIEF.md
# Programmable-Length Serial Delay Line

This block is a one-bit serial shift register whose active depth is chosen at run time, anywhere from 1 to 64 stages. Six binary-weighted length inputs decide which storage segments sit in the data path. A select line picks one of two serial inputs. Tying one of them to the block's own output lets a pattern recirculate.

Shifting is driven by two slow control lines, a shift clock and an active-high hold. Both are sampled in a free-running system clock domain. A shift happens on a rising shift clock while hold is low. It also happens on a falling hold while the shift clock is high, which gives negative-edge operation. A master reset clears the whole chain at once. The block drives the last active stage and its complement. Typical uses are variable digital delays and registers of odd length.

Top module: `prog_delay_line`

## Requirements
- R1: With `len_sel` bit i carrying weight 2^i (i = 0..5), the delay from `din` to `q` is the weighted sum plus one, counted in shift events.
- R2: With `len_sel` = 0 the chain is 1 stage long. With `len_sel` = 6'h3F it is 64 stages long.
- R3: On each shift, the bit entering the chain is `din_a` when `sel_a` = 1 and `din_b` when `sel_a` = 0.
- R4: A rising `line_clk` while `line_hold` is low causes exactly one shift. Outside shift events, no stage changes.
- R5: A falling `line_hold` while `line_clk` is high causes exactly one shift.
- R6: While `line_hold` is high, `line_clk` transitions cause no shift. A later release of `line_hold` while `line_clk` is low causes no shift either.
- R7: Raising `mrst` clears every stage and forces `q` to 0 at once, without waiting for a `sys_clk` edge. The chain stays clear while `mrst` is high, whatever the other inputs do.
- R8: `q_n` is always the logical complement of `q`.
- R9: A segment that is bypassed keeps its bits and does not shift. Changing `len_sel` changes the path that drives `q` without disturbing any stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running system clock that samples the control lines |
| mrst | input | 1 | Master reset, active high. Takes effect asynchronously; release is synchronized |
| line_clk | input | 1 | Shift clock line, acts on its rising edge |
| line_hold | input | 1 | Hold line. High blocks shifts; its falling edge shifts while `line_clk` is high |
| sel_a | input | 1 | Data select: 1 takes `din_a`, 0 takes `din_b` |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| len_sel | input | 6 | Length control. Bit i puts a segment of 2^i stages into the path |
| q | output | 1 | Last active stage |
| q_n | output | 1 | Complement of `q` |

## Verification
The condition hardest to reach from the ports is retention inside a bypassed segment. A stored bit there is invisible at `q` until its segment is switched back into the path. The stimulus first loads a two-stage chain so that the two stages hold different values. It then shortens the chain to one stage and shifts a value into the fixed stage that differs from the hidden bit. Finally it restores the length and expects the hidden bit to reappear at `q`. The full length sweep alternates between the two shift triggers and the two data sources, so each length is tested with both kinds of shift event.

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int NSEG = 6
) (
  input  logic            sys_clk,
  input  logic            mrst,
  input  logic            line_clk,
  input  logic            line_hold,
  input  logic            sel_a,
  input  logic            din_a,
  input  logic            din_b,
  input  logic [NSEG-1:0] len_sel,
  output logic            q,
  output logic            q_n
);

  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge sys_clk or posedge mrst)
    if (mrst) rst_pipe <= 2'b00;
    else      rst_pipe <= {rst_pipe[0], 1'b1};

  assign rst_n_i = rst_pipe[1];

  logic [1:0] clk_sync, hold_sync;
  logic       clk_prev, hold_prev;
  logic       clk_now, hold_now;

  always_ff @(posedge sys_clk or negedge rst_n_i)
    if (!rst_n_i) begin
      clk_sync  <= 2'b00;
      hold_sync <= 2'b11;
      clk_prev  <= 1'b0;
      hold_prev <= 1'b1;
    end else begin
      clk_sync  <= {clk_sync[0], line_clk};
      hold_sync <= {hold_sync[0], line_hold};
      clk_prev  <= clk_sync[1];
      hold_prev <= hold_sync[1];
    end

  assign clk_now  = clk_sync[1];
  assign hold_now = hold_sync[1];

  logic rise_evt, fall_evt, shift;
  assign rise_evt = clk_now & ~clk_prev & ~hold_now;
  assign fall_evt = hold_prev & ~hold_now & clk_now;
  assign shift    = rise_evt | fall_evt;

  logic din_sel;
  assign din_sel = sel_a ? din_a : din_b;

  logic fix0;
  always_ff @(posedge sys_clk or negedge rst_n_i)
    if (!rst_n_i)   fix0 <= 1'b0;
    else if (shift) fix0 <= din_sel;

  logic seg_in  [NSEG];
  logic seg_out [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int SLEN = 1 << i;
    logic [SLEN-1:0] seg;

    if (i == 0) begin : g_first
      assign seg_in[i] = fix0;
    end else begin : g_next
      assign seg_in[i] = seg_out[i-1];
    end

    if (SLEN == 1) begin : g_one
      always_ff @(posedge sys_clk or negedge rst_n_i)
        if (!rst_n_i)                 seg <= '0;
        else if (shift && len_sel[i]) seg <= seg_in[i];
    end else begin : g_many
      always_ff @(posedge sys_clk or negedge rst_n_i)
        if (!rst_n_i)                 seg <= '0;
        else if (shift && len_sel[i]) seg <= {seg[SLEN-2:0], seg_in[i]};
    end

    assign seg_out[i] = len_sel[i] ? seg[SLEN-1] : seg_in[i];

    AST_BYPASS_KEEPS: assert property (@(posedge sys_clk) disable iff (!rst_n_i)
      (shift && !len_sel[i]) |=> $stable(seg)); // R9
  end

  assign q   = seg_out[NSEG-1];
  assign q_n = ~q;

  AST_RESET_CLEARS: assert property (@(posedge sys_clk)
    mrst |-> (q == 1'b0)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge sys_clk) disable iff (!rst_n_i)
    !shift |=> $stable(fix0)); // R4
  AST_LOAD_SELECTED: assert property (@(posedge sys_clk) disable iff (!rst_n_i)
    shift |=> (fix0 == $past(sel_a ? din_a : din_b))); // R3
  AST_HOLD_BLOCKS: assert property (@(posedge sys_clk) disable iff (!rst_n_i)
    (hold_now && hold_prev) |=> $stable(fix0)); // R6
  AST_HOLD_FALL_SHIFTS: assert property (@(posedge sys_clk) disable iff (!rst_n_i)
    ($fell(hold_now) && clk_now) |=> (fix0 == $past(din_sel))); // R5
  AST_COMPLEMENT: assert property (@(posedge sys_clk)
    q_n != q); // R8

endmodule

// File: tb/tb_prog_delay_line.sv
module tb_prog_delay_line;
  logic sys_clk = 1'b0;
  logic mrst = 1'b1, line_clk = 1'b0, line_hold = 1'b0;
  logic sel_a = 1'b0, din_a = 1'b0, din_b = 1'b0;
  logic [5:0] len_sel = '0;
  logic q, q_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic hist [0:127];

  always #2.5 sys_clk = ~sys_clk;

  prog_delay_line dut (.sys_clk(sys_clk), .mrst(mrst), .line_clk(line_clk), .line_hold(line_hold),
    .sel_a(sel_a), .din_a(din_a), .din_b(din_b), .len_sel(len_sel), .q(q), .q_n(q_n));

  task automatic wait_n(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    mrst = 1'b1; line_clk = 1'b0; line_hold = 1'b0;
    wait_n(3);
    mrst = 1'b0;
    wait_n(4);
  endtask

  task automatic pulse_clk();
    line_clk = 1'b1; wait_n(4);
    line_clk = 1'b0; wait_n(4);
  endtask

  task automatic pulse_hold();
    line_hold = 1'b1; wait_n(4);
    line_clk = 1'b1;  wait_n(4);
    line_hold = 1'b0; wait_n(4);
    line_clk = 1'b0;  wait_n(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    check("R7 reset q", q, 1'b0);
    check("R8 reset q_n", q_n, 1'b1);

    // R1 R2 R3 R4 R5: sweep of every length
    for (int len = 1; len <= 64; len++) begin
      do_reset();
      len_sel = 6'(len - 1);
      for (int n = 0; n < len + 4; n++) begin
        logic expb;
        din_a = 1'(((n * 7 + len) >> 1) & 1);
        din_b = 1'(((n * 3 + len * 5) % 3) == 0);
        sel_a = 1'(n & 1);
        hist[n] = sel_a ? din_a : din_b;
        if (n % 5 == 2) pulse_hold(); else pulse_clk();
        expb = (n + 1 >= len) ? hist[n + 1 - len] : 1'b0;
        if (len == 1 || len == 64)
          check((n % 5 == 2) ? "R2 R5 R3 edge length" : "R2 R4 R3 edge length", q, expb);
        else
          check((n % 5 == 2) ? "R1 R5 R3 length" : "R1 R4 R3 length", q, expb);
        check("R8 complement", q_n, ~expb);
      end
    end

    // R6: hold blocks shifting
    do_reset();
    len_sel = 6'd0; sel_a = 1'b1; din_a = 1'b1;
    pulse_clk();
    check("R4 load one", q, 1'b1);
    din_a = 1'b0;
    line_hold = 1'b1; wait_n(4);
    for (int k = 0; k < 3; k++) pulse_clk();
    check("R6 held clock", q, 1'b1);
    line_hold = 1'b0; wait_n(4);
    check("R6 release low clk", q, 1'b1);
    pulse_clk();
    check("R4 after hold", q, 1'b0);

    // R7: asynchronous clear mid-run
    din_a = 1'b1; pulse_clk();
    check("R4 load before reset", q, 1'b1);
    #1 mrst = 1'b1;
    #0.5;
    check("R7 async clear", q, 1'b0);
    pulse_clk();
    check("R7 held in reset", q, 1'b0);
    mrst = 1'b0; wait_n(4);

    // R9: bypassed segment retains its bit
    do_reset();
    sel_a = 1'b0; len_sel = 6'd1;
    din_b = 1'b1; pulse_clk();
    din_b = 1'b0; pulse_clk();
    check("R9 two-stage out", q, 1'b1);
    len_sel = 6'd0; wait_n(1);
    check("R9 shortened path", q, 1'b0);
    din_b = 1'b0; pulse_clk();
    check("R9 one-stage shift", q, 1'b0);
    len_sel = 6'd1; wait_n(1);
    check("R9 retained bit", q, 1'b1);
    check("R8 retained complement", q_n, 1'b0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule